// File: doc/BRIEF.md
# Interrupt Level Acceptance Unit

This block decides, once per clock, whether the processor core takes an interrupt. It holds a 3-bit level mask that forms part of the processor status word. Each request source has its own request line and a programmable 3-bit level.

Among the pending sources, the unit picks the most urgent one. It grants that source only when the global interrupt-enable flag is set and the source's level is strictly below the mask. On a grant it emits a one-cycle acceptance pulse with the source index. In the same clock edge it loads the granted level into the mask, so only strictly more urgent requests can follow.

Software can write the mask with an 8-bit immediate, of which only the low three bits are kept. An interrupt return restores a previously saved mask. Requests are level-sensitive: the unit keeps no pending state of its own.

Top module: `ilvl_accept`

## Requirements
- R1: After reset the mask is 0 and the acceptance pulse is low.
- R2: A grant happens only when the enable input is 1, at least one request is high, and the chosen level is strictly below the mask. The grant shows as `accept_o` high for the cycle after the deciding clock edge, with `accept_idx_o` holding the source index.
- R3: On a grant, the mask takes the granted level at the same clock edge that raises `accept_o`.
- R4: Among pending requests, the one with the numerically lowest level is chosen.
- R5: When the mask is 0, no request is granted, including a request at level 0.
- R6: While the enable input is 0, no request is granted whatever its level.
- R7: A software write stores bits 2:0 of the 8-bit write data into the mask; bits 7:3 are ignored.
- R8: A restore loads the 3-bit saved value into the mask at the next clock edge.
- R9: In one cycle, a grant outranks a restore, and a restore outranks a software write.
- R10: A request whose level equals the mask is not granted.
- R11: A request that drops before it could be granted is never granted later, because no pending state is kept.
- R12: When several pending requests share the lowest level, the lowest source index wins.
- R13: Source i's level sits at bits 3*i+2 down to 3*i of `req_lvl_i`, and request i is bit i of `req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Level-sensitive request per source |
| req_lvl_i | input | N_SRC*3 | Packed 3-bit level per source |
| int_en_i | input | 1 | Global interrupt-enable flag |
| mask_wr_i | input | 1 | Software mask write strobe |
| mask_wdata_i | input | 8 | Immediate write data; low 3 bits used |
| restore_i | input | 1 | Restore saved mask (interrupt return) |
| restore_mask_i | input | 3 | Saved mask value |
| accept_o | output | 1 | One-cycle acceptance pulse |
| accept_idx_o | output | IDX_W | Index of the accepted source |
| mask_o | output | 3 | Current level mask |

## Verification
The assertions assume that request lines and levels are stable around the clock edge. They also assume that `accept_o` is read together with the mask as it stood on the previous cycle; for example, a grant implies that the previous mask was non-zero and strictly above the new one. To stay inside these assumptions, the stimulus changes inputs only on the falling edge. After a grant it drops the granted request before building the next scenario, so a request still held does not reach the next case.

// File: rtl/ilvl_accept.sv
module ilvl_accept #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  parameter int IMM_W = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] req_lvl_i,
  input  logic                   int_en_i,
  input  logic                   mask_wr_i,
  input  logic [IMM_W-1:0]       mask_wdata_i,
  input  logic                   restore_i,
  input  logic [LVL_W-1:0]       restore_mask_i,
  output logic                   accept_o,
  output logic [IDX_W-1:0]       accept_idx_o,
  output logic [LVL_W-1:0]       mask_o
);

  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             found;
  logic             take;
  logic [LVL_W-1:0] mask_q;
  logic             accept_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    best_lvl = '1;
    best_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!found || req_lvl_i[i*LVL_W +: LVL_W] < best_lvl)) begin
        found    = 1'b1;
        best_lvl = req_lvl_i[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign take = found && int_en_i && (best_lvl < mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      accept_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      accept_q <= take;
      if (take)           idx_q  <= best_idx;
      if (take)           mask_q <= best_lvl;
      else if (restore_i) mask_q <= restore_mask_i;
      else if (mask_wr_i) mask_q <= mask_wdata_i[LVL_W-1:0];
    end
  end

  assign mask_o       = mask_q;
  assign accept_o     = accept_q;
  assign accept_idx_o = idx_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_accept_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && accept_o) |-> $past(int_en_i));

  p_mask_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && accept_o) |-> (mask_o < $past(mask_o)));

  p_zero_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && accept_o) |-> ($past(mask_o) != '0));

  p_source_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && accept_o) |-> ((($past(req_i) >> accept_idx_o) & N_SRC'(1)) != '0));

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(restore_i) && !accept_o) |-> (mask_o == $past(restore_mask_i)));

  p_write_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mask_wr_i) && !$past(restore_i) && !accept_o)
      |-> (mask_o == $past(mask_wdata_i[LVL_W-1:0])));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !accept_o && !$past(restore_i) && !$past(mask_wr_i)) |-> $stable(mask_o));

endmodule

// File: tb/ilvl_accept_tb.sv
module ilvl_accept_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*3-1:0] lvl = '0;
  logic          en = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    wdata = '0;
  logic          rst_req = 1'b0;
  logic [2:0]    rmask = '0;
  logic          acc;
  logic [IW-1:0] idx;
  logic [2:0]    mask;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ilvl_accept #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_lvl_i(lvl), .int_en_i(en),
    .mask_wr_i(wr), .mask_wdata_i(wdata), .restore_i(rst_req),
    .restore_mask_i(rmask), .accept_o(acc), .accept_idx_o(idx), .mask_o(mask));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(input int i, input bit r, input logic [2:0] l);
    req[i] = r;
    lvl[i*3 +: 3] = l;
  endtask

  task automatic write_mask(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic t_reset();
    chk(mask == 3'd0, "R1 mask", mask, 0);
    chk(acc == 1'b0, "R1 accept", acc, 0);
  endtask

  task automatic t_write();
    write_mask(8'hFD);
    chk(mask == 3'd5, "R7 low bits", mask, 5);
    chk(acc == 1'b0, "R7 no accept", acc, 0);
  endtask

  task automatic t_basic();
    en = 1'b1;
    set_src(2, 1'b1, 3'd3);
    tick();
    chk(acc == 1'b1, "R2 accept", acc, 1);
    chk(idx == 3'd2, "R2 index", idx, 2);
    chk(mask == 3'd3, "R3 mask loaded", mask, 3);
    tick();
    chk(acc == 1'b0, "R2 pulse ends", acc, 0);
    set_src(2, 1'b0, 3'd0);
  endtask

  task automatic t_strict();
    set_src(1, 1'b1, 3'd3);
    tick(); tick();
    chk(acc == 1'b0, "R10 equal level", acc, 0);
    chk(mask == 3'd3, "R10 mask kept", mask, 3);
    set_src(1, 1'b0, 3'd0);
  endtask

  task automatic t_priority();
    write_mask(8'h07);
    set_src(0, 1'b1, 3'd6);
    set_src(5, 1'b1, 3'd2);
    set_src(3, 1'b1, 3'd4);
    tick();
    chk(acc == 1'b1 && idx == 3'd5, "R4 lowest level idx", idx, 5);
    chk(mask == 3'd2, "R4 mask", mask, 2);
    req = '0;
  endtask

  task automatic t_tie();
    write_mask(8'h07);
    set_src(6, 1'b1, 3'd1);
    set_src(4, 1'b1, 3'd1);
    tick();
    chk(acc == 1'b1 && idx == 3'd4, "R12 tie idx", idx, 4);
    req = '0;
  endtask

  task automatic t_enable_zero();
    write_mask(8'h07);
    en = 1'b0;
    set_src(1, 1'b1, 3'd0);
    tick(); tick();
    chk(acc == 1'b0, "R6 disabled", acc, 0);
    chk(mask == 3'd7, "R6 mask kept", mask, 7);
    en = 1'b1;
    tick();
    chk(acc == 1'b1 && idx == 3'd1, "R13 src1 level0 idx", idx, 1);
    chk(mask == 3'd0, "R3 mask to zero", mask, 0);
    req = '0;
    tick();
    set_src(3, 1'b1, 3'd0);
    tick(); tick();
    chk(acc == 1'b0, "R5 zero mask blocks", acc, 0);
    req = '0;
  endtask

  task automatic t_restore();
    rst_req = 1'b1; rmask = 3'd6;
    tick();
    rst_req = 1'b0;
    chk(mask == 3'd6, "R8 restore", mask, 6);
  endtask

  task automatic t_collide();
    set_src(2, 1'b1, 3'd4);
    rst_req = 1'b1; rmask = 3'd7;
    wr = 1'b1; wdata = 8'h01;
    tick();
    rst_req = 1'b0; wr = 1'b0; req = '0;
    chk(acc == 1'b1 && idx == 3'd2, "R9 accept wins", idx, 2);
    chk(mask == 3'd4, "R9 accept mask", mask, 4);
    rst_req = 1'b1; rmask = 3'd3;
    wr = 1'b1; wdata = 8'h02;
    tick();
    rst_req = 1'b0; wr = 1'b0;
    chk(mask == 3'd3, "R9 restore beats write", mask, 3);
  endtask

  task automatic t_no_pending();
    write_mask(8'h07);
    en = 1'b0;
    set_src(0, 1'b1, 3'd2);
    tick();
    req = '0;
    en = 1'b1;
    tick(); tick();
    chk(acc == 1'b0, "R11 dropped request", acc, 0);
    chk(mask == 3'd7, "R11 mask kept", mask, 7);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_basic();
    t_strict();
    t_priority();
    t_tie();
    t_enable_zero();
    t_restore();
    t_collide();
    t_no_pending();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule